// File: doc/BRIEF.md
# RTC Periodic Interrupt Divider

This block turns a 32768 Hz time-base enable pulse, delivered in the system clock domain, into a periodic interrupt flag at a rate picked by a 4-bit rate code. A free-running binary prescaler counts time-base pulses. A tap selector decoded from the rate code raises a periodic event each time the low bits of the prescaler roll over. The event sets a sticky flag that software clears by reading the status register. The interrupt line is that flag gated by an enable bit. The same tap can drive a square-wave output.

The rate code follows a power-of-two rule except at codes 1 and 2, which are remapped to 256 Hz and 128 Hz. Code 0 turns the periodic source off. A 3-bit divider-configuration field halts the divider for every value except one run code. Whenever the divider is halted, the rate code is 0, or the rate code changes, the prescaler is forced to zero. A fresh rate therefore always begins a full period from its start.

Top module: `rtc_periodic_div`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `pflag`, `irq` and `sq_out` are 0.
- R2: For rate codes 3 to 15, a flag event occurs once every 2^(code-1) time-base pulses.
- R3: Rate code 1 gives an event every 128 pulses (256 Hz) and code 2 gives one every 256 pulses (128 Hz).
- R4: Rate code 0 produces no flag event and leaves the prescaler at zero.
- R5: The divider runs only while `div_cfg` equals 3'b010. For any other value no event occurs, `sq_out` is 0 and the prescaler is held at zero. Counting resumes with the pulse of the first running cycle, so the first event comes on the 2^e-th pulse counted from that cycle, where e is the exponent for the code.
- R6: In the first cycle a new rate code is present, the prescaler clears and that cycle's pulse is not counted. The first event therefore comes 2^e counted pulses after that cycle.
- R7: `pflag` rises in the cycle after an event and stays high until a cycle with `status_rd` high clears it. If an event and a read fall in the same cycle, the flag stays set.
- R8: `irq` is registered as the AND of the next flag value and `pi_en`. It is never high without `pflag`, and it is low in the cycle after `pi_en` is 0.
- R9: When `sq_en` is 1 and the divider is active, `sq_out` equals bit e-1 of the prescaler value after each clock edge. This gives a square wave at the selected rate that is low for the first half of each period. `sq_out` is 0 whenever `sq_en` is 0.
- R10: The prescaler advances only in cycles where `tb_tick` is 1. With sparse pulses, an event still needs 2^e pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tb_tick | input | 1 | Single-cycle 32768 Hz time-base enable |
| rate_sel | input | 4 | Rate code; 0 turns the periodic source off |
| div_cfg | input | 3 | Divider configuration; only 3'b010 runs |
| pi_en | input | 1 | Periodic interrupt enable |
| sq_en | input | 1 | Square-wave output enable |
| status_rd | input | 1 | Status register read strobe; clears the flag |
| pflag | output | 1 | Sticky periodic flag |
| irq | output | 1 | Interrupt request, flag gated by enable |
| sq_out | output | 1 | Square wave at the selected rate |

## Verification
A prescaler that holds a wrong count, or a tap decoded to the wrong bit, moves the first flag after a rate change away from 2^e+1 cycles. That error shows at `pflag` within one period of the selected rate. Because `sq_out` exposes the tapped prescaler bit every cycle, a slip in the counter shows there within half a period, before the flag is due. A missed clear or a dropped event that collides with a read shows at `pflag` one cycle after the read.

// File: rtl/rtc_pid_pkg.sv
package rtc_pid_pkg;

  // control applied to the prescaler each cycle
  typedef struct packed {
    logic clr;
    logic inc;
  } pre_ctl_t;

  // number of low prescaler bits that make one period for a code
  function automatic int rate_exp(input int code, input int lo_exp, input int hi_exp);
    int e;
    if (code == 0)      e = 0;
    else if (code == 1) e = lo_exp;
    else if (code == 2) e = hi_exp;
    else                e = code - 1;
    return e;
  endfunction

endpackage

// File: rtl/rtc_rate_decode.sv
module rtc_rate_decode #(
  parameter int RATE_W = 4,
  parameter int CNT_W  = 14,
  parameter int LO_EXP = 7,
  parameter int HI_EXP = 8
) (
  input  logic [RATE_W-1:0] code,
  output logic [CNT_W-1:0]  mask,
  output logic [CNT_W-1:0]  tap
);
  import rtc_pid_pkg::*;

  int e_v;

  always_comb begin
    e_v = rate_exp(int'(code), LO_EXP, HI_EXP);
  end

  // one mask bit and one tap bit per prescaler stage
  for (genvar i = 0; i < CNT_W; i++) begin : g_stage
    assign mask[i] = (i < e_v);
    assign tap[i]  = (i == e_v - 1);
  end

endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int CNT_W = 14
) (
  input  logic                 clk,
  input  logic                 rst,
  input  rtc_pid_pkg::pre_ctl_t ctl,
  output logic [CNT_W-1:0]     cnt,
  output logic [CNT_W-1:0]     cnt_nxt
);

  always_comb begin
    if (ctl.clr)      cnt_nxt = '0;
    else if (ctl.inc) cnt_nxt = cnt + 1'b1;
    else              cnt_nxt = cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt_nxt;
  end

endmodule

// File: rtl/rtc_tap_select.sv
module rtc_tap_select #(
  parameter int CNT_W = 14
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [CNT_W-1:0] mask,
  input  logic [CNT_W-1:0] tap,
  input  logic             inc,
  input  logic             active,
  input  logic             sq_en,
  output logic             evt,
  output logic             sq_d
);

  // event on the pulse that rolls the low e bits over
  always_comb begin
    evt  = inc && (|mask) && ((cnt & mask) == mask);
    sq_d = sq_en && active && (|(cnt_nxt & tap));
  end

endmodule

// File: rtl/rtc_flag_ctrl.sv
module rtc_flag_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic evt,
  input  logic rd,
  input  logic pi_en,
  input  logic sq_d,
  output logic pflag,
  output logic irq,
  output logic sq_out
);

  logic pflag_n;

  // a set from an event outranks a clear from a read
  always_comb begin
    pflag_n = evt | (pflag & ~rd);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pflag  <= 1'b0;
      irq    <= 1'b0;
      sq_out <= 1'b0;
    end else begin
      pflag  <= pflag_n;
      irq    <= pflag_n & pi_en;
      sq_out <= sq_d;
    end
  end

endmodule

// File: rtl/rtc_periodic_div.sv
module rtc_periodic_div #(
  parameter int             RATE_W  = 4,
  parameter int             DIV_W   = 3,
  parameter logic [DIV_W-1:0] DIV_RUN = 3'b010,
  parameter int             CNT_W   = 14,
  parameter int             LO_EXP  = 7,
  parameter int             HI_EXP  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tb_tick,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic [DIV_W-1:0]  div_cfg,
  input  logic              pi_en,
  input  logic              sq_en,
  input  logic              status_rd,
  output logic              pflag,
  output logic              irq,
  output logic              sq_out
);
  import rtc_pid_pkg::*;

  logic [RATE_W-1:0] prev_rate;
  logic              run, changed, off, active;
  pre_ctl_t          ctl;
  logic [CNT_W-1:0]  cnt, cnt_nxt, mask, tap;
  logic              evt, sq_d;

  always_ff @(posedge clk) begin
    if (rst) prev_rate <= '0;
    else     prev_rate <= rate_sel;
  end

  always_comb begin
    run     = (div_cfg == DIV_RUN);
    changed = (rate_sel != prev_rate);
    off     = (rate_sel == '0);
    ctl.clr = !run || changed || off;
    ctl.inc = tb_tick && !ctl.clr;
    active  = !ctl.clr;
  end

  rtc_rate_decode #(
    .RATE_W(RATE_W), .CNT_W(CNT_W), .LO_EXP(LO_EXP), .HI_EXP(HI_EXP)
  ) u_dec (
    .code(rate_sel), .mask(mask), .tap(tap)
  );

  rtc_prescaler #(.CNT_W(CNT_W)) u_pre (
    .clk(clk), .rst(rst), .ctl(ctl), .cnt(cnt), .cnt_nxt(cnt_nxt)
  );

  rtc_tap_select #(.CNT_W(CNT_W)) u_tap (
    .cnt(cnt), .cnt_nxt(cnt_nxt), .mask(mask), .tap(tap),
    .inc(ctl.inc), .active(active), .sq_en(sq_en),
    .evt(evt), .sq_d(sq_d)
  );

  rtc_flag_ctrl u_flag (
    .clk(clk), .rst(rst), .evt(evt), .rd(status_rd), .pi_en(pi_en),
    .sq_d(sq_d), .pflag(pflag), .irq(irq), .sq_out(sq_out)
  );

endmodule

// File: rtl/rtc_periodic_div_chk.sv
module rtc_periodic_div_chk #(
  parameter int             RATE_W  = 4,
  parameter int             DIV_W   = 3,
  parameter logic [DIV_W-1:0] DIV_RUN = 3'b010
) (
  input logic              clk,
  input logic              rst,
  input logic              tb_tick,
  input logic [RATE_W-1:0] rate_sel,
  input logic [DIV_W-1:0]  div_cfg,
  input logic              pi_en,
  input logic              sq_en,
  input logic              status_rd,
  input logic              pflag,
  input logic              irq,
  input logic              sq_out
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!pflag && !irq && !sq_out));

  assert_zero_code_silent_R4: assert property (@(posedge clk) disable iff (rst)
    (rate_sel == '0) |=> !$rose(pflag));

  assert_halted_silent_R5: assert property (@(posedge clk) disable iff (rst)
    (div_cfg != DIV_RUN) |=> (!$rose(pflag) && !sq_out));

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (status_rd && !tb_tick) |=> !pflag);

  assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (rst)
    irq |-> pflag);

  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (rst)
    !pi_en |=> !irq);

  assert_sq_gated_R9: assert property (@(posedge clk) disable iff (rst)
    !sq_en |=> !sq_out);

  assert_flag_needs_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    !tb_tick |=> !$rose(pflag));

endmodule

bind rtc_periodic_div rtc_periodic_div_chk #(
  .RATE_W(RATE_W), .DIV_W(DIV_W), .DIV_RUN(DIV_RUN)
) u_chk (
  .clk(clk), .rst(rst), .tb_tick(tb_tick), .rate_sel(rate_sel),
  .div_cfg(div_cfg), .pi_en(pi_en), .sq_en(sq_en), .status_rd(status_rd),
  .pflag(pflag), .irq(irq), .sq_out(sq_out)
);

// File: tb/rtc_periodic_div_tb.sv
`timescale 1ns/1ps
module rtc_periodic_div_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tb_tick = 1'b0;
  logic [3:0] rate_sel = '0;
  logic [2:0] div_cfg = 3'b010;
  logic       pi_en = 1'b0;
  logic       sq_en = 1'b0;
  logic       status_rd = 1'b0;
  logic       pflag, irq, sq_out;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  rtc_periodic_div u_dut (
    .clk(clk), .rst(rst), .tb_tick(tb_tick), .rate_sel(rate_sel),
    .div_cfg(div_cfg), .pi_en(pi_en), .sq_en(sq_en), .status_rd(status_rd),
    .pflag(pflag), .irq(irq), .sq_out(sq_out)
  );

  function automatic int exp_of(input int code);
    if (code == 1) return 7;
    if (code == 2) return 8;
    return code - 1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // counts falling edges until pflag is seen high, releasing any read strobe
  task automatic wait_flag(input int lim, output int n);
    n = 0;
    do begin
      @(negedge clk);
      status_rd = 1'b0;
      n++;
    end while (!pflag && n < lim);
  endtask

  task automatic quiet(input int cycles, output int hits);
    hits = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      status_rd = 1'b0;
      if (pflag || irq || sq_out) hits++;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n, hits, e, per;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk(pflag == 1'b0, "R1 pflag", pflag, 0);
    chk(irq == 1'b0, "R1 irq", irq, 0);
    chk(sq_out == 1'b0, "R1 sq_out", sq_out, 0);
    rst = 1'b0;
    tb_tick = 1'b1;
    pi_en = 1'b1;
    sq_en = 1'b1;

    // R2 R3 R6 sweep of every nonzero code
    for (int code = 1; code < 16; code++) begin
      e = exp_of(code);
      per = 1 << e;
      @(negedge clk);
      rate_sel = code[3:0];
      status_rd = 1'b1;
      wait_flag(per + 8, n);
      chk(n == per + 1, (code < 3) ? "R3 first period" : "R6 first period", n, per + 1);
      chk(irq == 1'b1, "R8 irq follows flag", irq, 1);
      status_rd = 1'b1;
      wait_flag(per + 8, n);
      chk(n == per, (code < 3) ? "R3 period" : "R2 period", n, per);
    end

    // R4 code zero
    @(negedge clk);
    rate_sel = 4'd0;
    status_rd = 1'b1;
    sq_en = 1'b1;
    quiet(600, hits);
    chk(hits == 0, "R4 code zero silent", hits, 0);

    // R5 every halted divider value, then resume
    rate_sel = 4'd3;
    status_rd = 1'b1;
    for (int d = 0; d < 8; d++) begin
      if (d != 2) begin
        @(negedge clk);
        div_cfg = d[2:0];
        quiet(24, hits);
        chk(hits == 0, "R5 halted silent", hits, 0);
      end
    end
    @(negedge clk);
    div_cfg = 3'b010;
    wait_flag(40, n);
    chk(n == 4, "R5 resume period", n, 4);

    // R7 collision and plain clear
    @(negedge clk);
    rate_sel = 4'd4;
    status_rd = 1'b1;
    wait_flag(6, n);
    @(negedge clk);
    rate_sel = 4'd3;
    status_rd = 1'b1;
    repeat (4) begin
      @(negedge clk);
      status_rd = 1'b0;
    end
    chk(pflag == 1'b0, "R7 flag before event", pflag, 0);
    status_rd = 1'b1;
    @(negedge clk);
    chk(pflag == 1'b1, "R7 event wins over read", pflag, 1);
    status_rd = 1'b1;
    @(negedge clk);
    status_rd = 1'b0;
    chk(pflag == 1'b0, "R7 read clears", pflag, 0);
    repeat (2) @(negedge clk);
    chk(pflag == 1'b0, "R7 stays clear", pflag, 0);
    @(negedge clk);
    chk(pflag == 1'b1, "R7 sticky set", pflag, 1);
    repeat (3) @(negedge clk);
    chk(pflag == 1'b1, "R7 sticky hold", pflag, 1);

    // R8 enable gating
    @(negedge clk);
    pi_en = 1'b0;
    @(negedge clk);
    chk(irq == 1'b0, "R8 irq masked", irq, 0);
    chk(pflag == 1'b1, "R8 flag kept", pflag, 1);
    pi_en = 1'b1;
    @(negedge clk);
    chk(irq == 1'b1, "R8 irq unmasked", irq, 1);

    // R9 square wave shape for codes 3 and 4
    for (int code = 3; code < 5; code++) begin
      e = exp_of(code);
      per = 1 << e;
      @(negedge clk);
      rate_sel = 4'd9;
      @(negedge clk);
      rate_sel = code[3:0];
      for (int k = 1; k <= 2 * per; k++) begin
        @(negedge clk);
        chk(sq_out == (((k - 1) % per) >> (e - 1)) % 2, "R9 square wave", sq_out,
            (((k - 1) % per) >> (e - 1)) % 2);
      end
    end
    @(negedge clk);
    sq_en = 1'b0;
    @(negedge clk);
    hits = 0;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      if (sq_out) hits++;
    end
    chk(hits == 0, "R9 square wave off", hits, 0);

    // R10 sparse pulses, one every third cycle
    @(negedge clk);
    rate_sel = 4'd5;
    tb_tick = 1'b0;
    status_rd = 1'b1;
    @(negedge clk);
    rate_sel = 4'd3;
    n = 0;
    do begin
      @(negedge clk);
      status_rd = 1'b0;
      n++;
      tb_tick = (n % 3 == 1);
    end while (!pflag && n < 40);
    chk(n == 11, "R10 sparse pulses", n, 11);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule